// File: doc/BRIEF.md
# Sequential Switch Polling Controller

This block watches a bank of switch inputs while drawing little current. It does not bias every switch at once. Instead it walks through the channels one after another, from the lowest index to the highest. For each selected channel it turns on that channel's wetting-current enable for a programmable active window. It then captures the comparator result for that channel on the last microsecond of the window. A full pass over all channels is a scan. Scans repeat at a programmable period, so the host processor can sleep in between.

Scanning runs while the trigger configuration bit is 1. The first scan after the trigger is set produces a baseline: every sampled value is stored as that channel's reference state, and the interrupt is raised unconditionally to tell the host the baseline is ready. In later scans a channel whose sample differs from its stored state has its stored state updated. If interrupts are enabled for that channel, the block also sets the switch-change flag and drives the active-low interrupt output. The host clears the flag with a one-cycle read strobe on the status register.

Time is counted in microsecond ticks produced by a divider from the system clock. The active window is 64·2^n µs for a 3-bit code n, and the scan period is 2·2^n ms for a 4-bit code n. Codes beyond the largest step saturate.

Top module: `switch_poll_ctrl`

## Requirements
- R1: While reset is asserted, all current enables are 0, `int_n` is 1, `stat_ssc` is 0 and `sw_state` is all zeros.
- R2: While `cfg_trigger` is 0, no current enable is asserted and `sw_state` does not change.
- R3: At most one current enable is high at any time. Successive windows step through channel indices in increasing order, and channel 0 follows channel NUM_CH-1.
- R4: Each active window lasts `ACT_BASE_US << min(cfg_act_code, 5)` microsecond ticks. A window that begins on a tick lasts exactly that many ticks times CLK_PER_US cycles. The first window after the trigger is set may be up to one tick shorter.
- R5: From the second scan onward, scans start every `max(PER_BASE_US << min(cfg_per_code, 11), NUM_CH × window)` ticks. When the window total reaches the period, the next scan starts directly after the last channel.
- R6: At the end of the first scan after the trigger is set, `sw_state` holds every channel's sampled comparator value, and `stat_ssc` rises (with `int_n` falling) even when all channel interrupt enables are 0. This happens on the clock edge of the last channel's final tick.
- R7: In later scans, a sample that differs from the stored bit in `sw_state` replaces that bit. `stat_ssc` is set only if the channel's bit in `cfg_int_en` is 1. Unchanged samples raise nothing.
- R8: Once set, `stat_ssc` stays 1 until a cycle with `stat_rd` high. That cycle clears it on the next edge, unless a new change is recorded on the same edge. `int_n` is always the inverse of `stat_ssc`.
- R9: A channel whose `cfg_zero_cur` bit is 1 never has its current enable asserted. Its comparator is still sampled, it still updates `sw_state`, and it can still raise an interrupt.
- R10: Clearing `cfg_trigger` drops all current enables on the next clock edge. The next time the trigger is set, the scan is treated as a first scan and interrupts unconditionally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trigger | input | 1 | Polling run bit from the configuration register |
| cfg_act_code | input | 3 | Active-window code, 64·2^n µs, saturating at n=5 |
| cfg_per_code | input | 4 | Scan-period code, 2·2^n ms, saturating at n=11 |
| cfg_int_en | input | NUM_CH | Per-channel interrupt enable |
| cfg_zero_cur | input | NUM_CH | Per-channel zero-current selection |
| comp_in | input | NUM_CH | Comparator results, one per channel |
| stat_rd | input | 1 | One-cycle read strobe of the interrupt status register |
| wet_en | output | NUM_CH | Per-channel wetting-current enable |
| int_n | output | 1 | Active-low interrupt |
| stat_ssc | output | 1 | Switch-status-change flag |
| sw_state | output | NUM_CH | Stored switch status per channel |

## Verification
The current enables come from the registered channel state through combinational decoding. A window that begins on a microsecond-tick edge is therefore visible at the following falling clock edge and lasts exactly a whole number of tick periods. The bench measures window lengths and scan-start spacing at falling edges, which gives exact cycle counts. The only exception is the first window after the trigger, which is held to a one-tick range.

The end-of-first-scan interrupt is due 24·window ticks after the edge that starts the scan, which lands 96 or 97 falling edges after the trigger is driven in the small configuration. It is checked in that range. A read strobe takes effect on the next edge, so its result is sampled one falling edge later. Changed comparator inputs are given more than two scan periods before `sw_state` and `int_n` are checked.

// File: rtl/swpoll_pkg.sv
package swpoll_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_ACTIVE = 2'd1,
        PH_WAIT   = 2'd2
    } phase_e;

    function automatic logic [3:0] sat_code(input logic [3:0] code, input logic [3:0] lim);
        return (code > lim) ? lim : code;
    endfunction

endpackage

// File: rtl/swpoll_tick.sv
// Free-running divider: one-cycle pulse every CLK_PER_US clocks.
module swpoll_tick #(
    parameter int CLK_PER_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
    localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/swpoll_decode.sv
// Turns the window and period codes into tick counts.
module swpoll_decode #(
    parameter int ACT_BASE_US = 64,
    parameter int PER_BASE_US = 2000,
    parameter int AW          = 12,
    parameter int CW          = 22
) (
    input  logic [2:0]    act_code,
    input  logic [3:0]    per_code,
    output logic [AW-1:0] act_len,
    output logic [CW-1:0] per_len
);
    import swpoll_pkg::*;

    logic [3:0] act_sh, per_sh;

    always_comb begin
        act_sh  = sat_code({1'b0, act_code}, 4'd5);
        per_sh  = sat_code(per_code, 4'd11);
        act_len = AW'(ACT_BASE_US) << act_sh;
        per_len = CW'(PER_BASE_US) << per_sh;
    end
endmodule

// File: rtl/swpoll_wet.sv
// One enable per channel: the selected channel during its window, unless zero-current.
module swpoll_wet #(
    parameter int NUM_CH = 24,
    parameter int CHW    = 5
) (
    input  logic              active,
    input  logic [CHW-1:0]    ch,
    input  logic [NUM_CH-1:0] zero_cur,
    output logic [NUM_CH-1:0] wet_en
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign wet_en[i] = active && (ch == CHW'(i)) && !zero_cur[i];
    end
endmodule

// File: rtl/switch_poll_ctrl.sv
module switch_poll_ctrl #(
    parameter int NUM_CH      = 24,
    parameter int CLK_PER_US  = 250,
    parameter int ACT_BASE_US = 64,
    parameter int PER_BASE_US = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_trigger,
    input  logic [2:0]        cfg_act_code,
    input  logic [3:0]        cfg_per_code,
    input  logic [NUM_CH-1:0] cfg_int_en,
    input  logic [NUM_CH-1:0] cfg_zero_cur,
    input  logic [NUM_CH-1:0] comp_in,
    input  logic              stat_rd,
    output logic [NUM_CH-1:0] wet_en,
    output logic              int_n,
    output logic              stat_ssc,
    output logic [NUM_CH-1:0] sw_state
);
    import swpoll_pkg::*;

    localparam int CHW      = $clog2(NUM_CH);
    localparam int ACT_MAX  = ACT_BASE_US * 32;
    localparam int PER_MAX  = PER_BASE_US * 2048;
    localparam int SCAN_MAX = NUM_CH * ACT_MAX;
    localparam int CNT_MAX  = (PER_MAX > SCAN_MAX) ? PER_MAX : SCAN_MAX;
    localparam int AW       = $clog2(ACT_MAX + 1);
    localparam int CW       = $clog2(CNT_MAX + 1);
    localparam logic [CHW-1:0] LAST_CH = CHW'(NUM_CH - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CHW-1:0]    ch;
        logic [AW-1:0]     act_cnt;
        logic [CW-1:0]     per_cnt;
        logic [NUM_CH-1:0] base;
        logic              first;
        logic              ssc;
    } poll_st_t;

    localparam poll_st_t RST_ST = '{phase: PH_IDLE, ch: '0, act_cnt: '0, per_cnt: '0,
                                    base: '0, first: 1'b1, ssc: 1'b0};

    poll_st_t q, d;
    logic          tick;
    logic [AW-1:0] act_len;
    logic [CW-1:0] per_len;
    logic          smp;
    logic          set_ssc;

    swpoll_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    swpoll_decode #(
        .ACT_BASE_US (ACT_BASE_US),
        .PER_BASE_US (PER_BASE_US),
        .AW          (AW),
        .CW          (CW)
    ) u_decode (
        .act_code (cfg_act_code),
        .per_code (cfg_per_code),
        .act_len  (act_len),
        .per_len  (per_len)
    );

    swpoll_wet #(.NUM_CH(NUM_CH), .CHW(CHW)) u_wet (
        .active   (q.phase == PH_ACTIVE),
        .ch       (q.ch),
        .zero_cur (cfg_zero_cur),
        .wet_en   (wet_en)
    );

    always_comb begin
        d       = q;
        smp     = 1'b0;
        set_ssc = 1'b0;
        if (!cfg_trigger) begin
            d.phase   = PH_IDLE;
            d.first   = 1'b1;
            d.ch      = '0;
            d.act_cnt = '0;
            d.per_cnt = '0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    d.phase   = PH_ACTIVE;
                    d.ch      = '0;
                    d.act_cnt = '0;
                    d.per_cnt = '0;
                end
                PH_ACTIVE: begin
                    if (tick) begin
                        d.per_cnt = q.per_cnt + 1'b1;
                        if (q.act_cnt >= act_len - 1'b1) begin
                            smp       = comp_in[q.ch];
                            d.act_cnt = '0;
                            if (q.first) begin
                                d.base[q.ch] = smp;
                            end else if (smp != q.base[q.ch]) begin
                                d.base[q.ch] = smp;
                                set_ssc      = cfg_int_en[q.ch];
                            end
                            if (q.ch == LAST_CH) begin
                                if (q.first) begin
                                    set_ssc = 1'b1;
                                    d.first = 1'b0;
                                end
                                if (q.per_cnt >= per_len - 1'b1) begin
                                    d.ch      = '0;
                                    d.per_cnt = '0;
                                end else begin
                                    d.phase = PH_WAIT;
                                end
                            end else begin
                                d.ch = q.ch + 1'b1;
                            end
                        end else begin
                            d.act_cnt = q.act_cnt + 1'b1;
                        end
                    end
                end
                PH_WAIT: begin
                    if (tick) begin
                        if (q.per_cnt >= per_len - 1'b1) begin
                            d.phase   = PH_ACTIVE;
                            d.ch      = '0;
                            d.act_cnt = '0;
                            d.per_cnt = '0;
                        end else begin
                            d.per_cnt = q.per_cnt + 1'b1;
                        end
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
        end
        d.ssc = (q.ssc & ~stat_rd) | set_ssc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    assign stat_ssc = q.ssc;
    assign int_n    = ~q.ssc;
    assign sw_state = q.base;
endmodule

// File: rtl/switch_poll_ctrl_chk.sv
module switch_poll_ctrl_chk #(
    parameter int NUM_CH = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_trigger,
    input logic [NUM_CH-1:0] cfg_zero_cur,
    input logic              stat_rd,
    input logic [NUM_CH-1:0] wet_en,
    input logic              stat_ssc,
    input logic [NUM_CH-1:0] sw_state
);
    assert_one_channel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wet_en));

    assert_step_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wet_en != '0 && $past(wet_en) != '0 && wet_en != $past(wet_en)) |->
        (wet_en == ($past(wet_en) << 1) || (wet_en[0] && $past(wet_en[NUM_CH-1]))));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_trigger |=> wet_en == '0);

    assert_frozen_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_trigger |=> $stable(sw_state));

    assert_zero_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wet_en & cfg_zero_cur) == '0);

    assert_clear_needs_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_ssc) |-> $past(stat_rd));

    assert_hold_until_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ssc && !stat_rd) |=> stat_ssc);

    assert_set_while_scanning_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_ssc) |-> $past(cfg_trigger));
endmodule

bind switch_poll_ctrl switch_poll_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_trigger  (cfg_trigger),
    .cfg_zero_cur (cfg_zero_cur),
    .stat_rd      (stat_rd),
    .wet_en       (wet_en),
    .stat_ssc     (stat_ssc),
    .sw_state     (sw_state)
);

// File: tb/switch_poll_ctrl_test.sv
`timescale 1ns/1ps
module switch_poll_ctrl_test;
    localparam int N  = 24;
    localparam int C  = 2;   // clocks per microsecond tick
    localparam int AB = 2;   // window base, us
    localparam int PB = 1;   // period base, us

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_trigger = 1'b0;
    logic [2:0]    cfg_act_code = '0;
    logic [3:0]    cfg_per_code = '0;
    logic [N-1:0]  cfg_int_en = '0;
    logic [N-1:0]  cfg_zero_cur = '0;
    logic [N-1:0]  comp_in = '0;
    logic          stat_rd = 1'b0;
    logic [N-1:0]  wet_en;
    logic          int_n;
    logic          stat_ssc;
    logic [N-1:0]  sw_state;

    always #2 clk = ~clk;

    switch_poll_ctrl #(.NUM_CH(N), .CLK_PER_US(C), .ACT_BASE_US(AB), .PER_BASE_US(PB)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_trigger(cfg_trigger), .cfg_act_code(cfg_act_code),
        .cfg_per_code(cfg_per_code), .cfg_int_en(cfg_int_en), .cfg_zero_cur(cfg_zero_cur),
        .comp_in(comp_in), .stat_rd(stat_rd), .wet_en(wet_en), .int_n(int_n),
        .stat_ssc(stat_ssc), .sw_state(sw_state)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // window monitor
    longint cyc = 0;
    bit     mon_en = 1'b0;
    bit     first_win;
    int     exp_l, exp_p, exp_next, starts;
    longint start_cyc, last_ch0;
    logic [N-1:0] prev_w = '0;
    logic [N-1:0] seen_mask = '0;

    always @(negedge clk) begin
        cyc++;
        seen_mask <= seen_mask | wet_en;
        if (mon_en && wet_en != prev_w) begin
            if (prev_w != '0) begin
                if (first_win)
                    check((cyc - start_cyc) >= (exp_l - 1) * C + 1 && (cyc - start_cyc) <= exp_l * C,
                          "R4", "first window length", cyc - start_cyc, exp_l * C);
                else
                    check((cyc - start_cyc) == exp_l * C, "R4", "window length",
                          cyc - start_cyc, exp_l * C);
                first_win = 1'b0;
            end
            if (wet_en != '0) begin
                int ch = 0;
                for (int i = 0; i < N; i++) if (wet_en[i]) ch = i;
                check($countones(wet_en) == 1, "R3", "single enable", $countones(wet_en), 1);
                check(ch == exp_next, "R3", "channel order", ch, exp_next);
                exp_next  = (ch + 1) % N;
                start_cyc = cyc;
                if (ch == 0) begin
                    starts++;
                    if (starts >= 3)
                        check((cyc - last_ch0) == exp_p, "R5", "scan period", cyc - last_ch0, exp_p);
                    last_ch0 = cyc;
                end
            end
            prev_w = wet_en;
        end
    end

    function automatic int win_us(input int code);
        return AB << ((code > 5) ? 5 : code);
    endfunction

    function automatic int per_cyc(input int acode, input int pcode);
        int p = PB << ((pcode > 11) ? 11 : pcode);
        int s = N * win_us(acode);
        return ((p > s) ? p : s) * C;
    endfunction

    task automatic run_cfg(input int a, input int p);
        @(negedge clk);
        cfg_trigger  = 1'b0;
        cfg_act_code = 3'(a);
        cfg_per_code = 4'(p);
        repeat (3) @(negedge clk);
        exp_l = win_us(a); exp_p = per_cyc(a, p);
        exp_next = 0; starts = 0; first_win = 1'b1; prev_w = '0;
        mon_en = 1'b1;
        cfg_trigger = 1'b1;
        for (int k = 0; k < 30000 && starts < 3; k++) @(negedge clk);
        check(starts >= 3, "R5", "scans started", starts, 3);
        mon_en = 1'b0;
        cfg_trigger = 1'b0;
        @(negedge clk);
        check(wet_en == '0, "R10", "enables off after clear", wet_en, 0);
    endtask

    task automatic pulse_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_int(input int limit, output int n);
        n = 0;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            n++;
            if (!int_n) break;
        end
    endtask

    initial begin
        int n;
        logic [N-1:0] pat;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(wet_en == '0, "R1", "enables in reset", wet_en, 0);
        check(int_n == 1'b1, "R1", "int_n in reset", int_n, 1);
        check(stat_ssc == 1'b0, "R1", "flag in reset", stat_ssc, 0);
        check(sw_state == '0, "R1", "status in reset", sw_state, 0);
        rst_n = 1'b1;
        comp_in = 24'hA5C3F0;
        // R2 idle without trigger
        seen_mask = '0;
        repeat (300) @(negedge clk);
        check(seen_mask == '0, "R2", "enables while idle", seen_mask, 0);
        check(sw_state == '0, "R2", "status while idle", sw_state, 0);
        check(stat_ssc == 1'b0, "R2", "flag while idle", stat_ssc, 0);

        // R3 R4 R5: window code sweep, then period code sweep
        for (int a = 0; a < 8; a++) run_cfg(a, 0);
        for (int p = 0; p < 16; p++) if (p <= 12 || p == 15) run_cfg(0, p);

        // R6: first scan baseline and unconditional interrupt
        @(negedge clk);
        cfg_act_code = 3'd0; cfg_per_code = 4'd6; cfg_int_en = '0;
        pat = 24'h5A3C81; comp_in = pat;
        pulse_read();
        check(int_n == 1'b1 && stat_ssc == 1'b0, "R8", "cleared by read", stat_ssc, 0);
        cfg_trigger = 1'b1;
        wait_int(400, n);
        check(n >= 96 && n <= 97, "R6", "first-scan interrupt delay", n, 96);
        check(sw_state == pat, "R6", "baseline", sw_state, pat);
        check(stat_ssc == 1'b1, "R6", "flag after first scan", stat_ssc, 1);
        repeat (50) @(negedge clk);
        check(int_n == 1'b0, "R8", "held until read", int_n, 0);
        pulse_read();
        check(int_n == 1'b1 && stat_ssc == 1'b0, "R8", "read releases int_n", int_n, 1);

        // R7: no change, change on disabled channel, changes on enabled channels
        repeat (300) @(negedge clk);
        check(int_n == 1'b1, "R7", "no change no interrupt", int_n, 1);
        pat[5] = ~pat[5]; comp_in = pat;
        repeat (300) @(negedge clk);
        check(sw_state == pat, "R7", "disabled channel updates status", sw_state, pat);
        check(int_n == 1'b1, "R7", "disabled channel silent", int_n, 1);
        cfg_int_en = '0; cfg_int_en[9] = 1'b1; cfg_int_en[23] = 1'b1; cfg_int_en[0] = 1'b1;
        for (int j = 0; j < 3; j++) begin
            int b = (j == 0) ? 9 : (j == 1) ? 23 : 0;
            pat[b] = ~pat[b]; comp_in = pat;
            wait_int(300, n);
            check(int_n == 1'b0, "R7", $sformatf("change on ch%0d interrupts", b), int_n, 0);
            check(sw_state == pat, "R7", "status tracks change", sw_state, pat);
            pulse_read();
        end

        // R9: zero-current channels
        cfg_zero_cur = '0; cfg_zero_cur[3] = 1'b1; cfg_zero_cur[23] = 1'b1;
        cfg_int_en[3] = 1'b1;
        seen_mask = '0;
        pat[3] = ~pat[3]; comp_in = pat;
        wait_int(300, n);
        check(int_n == 1'b0, "R9", "zero-current channel interrupts", int_n, 0);
        check(sw_state == pat, "R9", "zero-current channel sampled", sw_state, pat);
        repeat (200) @(negedge clk);
        check(seen_mask == ~cfg_zero_cur, "R9", "enable coverage", seen_mask, ~cfg_zero_cur);
        pulse_read();
        cfg_zero_cur = '0;

        // R10: clear mid-scan, then retrigger acts as first scan
        for (int k = 0; k < 400 && !wet_en[10]; k++) @(negedge clk);
        check(wet_en[10] == 1'b1, "R10", "reached ch10", wet_en[10], 1);
        cfg_trigger = 1'b0;
        @(negedge clk);
        check(wet_en == '0, "R10", "stop at once", wet_en, 0);
        repeat (20) @(negedge clk);
        check(wet_en == '0 && int_n == 1'b1, "R10", "stays stopped", wet_en, 0);
        cfg_trigger = 1'b1;
        wait_int(400, n);
        check(n >= 96 && n <= 97, "R10", "retrigger interrupts as first scan", n, 96);
        check(sw_state == pat, "R10", "baseline after retrigger", sw_state, pat);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule